// File: doc/BRIEF.md
# Byte-Lane Steering Bus Sequencer

This block turns a CPU-side memory request into cycles on a 16-bit external data bus. That bus is built from two 8-bit banks. The byte at each even address sits in the low bank on data bits 7:0, and the byte at each odd address sits in the high bank on data bits 15:8. Both banks share one word address, which is the byte address shifted right by one.

The requester gives:
- a 20-bit byte address,
- a size (byte or 16-bit word),
- a direction,
- write data.

The sequencer then drives the word address, the low-bank enable (active low, high when idle) and the active-low high-bank enable. It places write bytes on the lane that owns them and gathers read bytes from the lane that returned them.

A word at an odd address crosses both banks at two different word addresses, so it cannot complete in one cycle. The sequencer splits it into two byte cycles without a second request. The high lane goes first and carries the word's low byte. The low lane goes second, at the next word address, and carries the high byte. The read result is put back together, so the requester never sees the split. Every external cycle is held until a ready input is sampled high. A single done pulse marks the end of the whole access.

Top module: `bank_lane_seq`

## Requirements
- R1: After reset and whenever no external cycle is running, bus_lo_en_n = 1, bus_hi_en_n = 1, bus_we = 0 and bus_cyc = 0.
- R2: A byte access to an even address runs one cycle with bus_lo_en_n = 0, bus_hi_en_n = 1 and bus_addr = addr[19:1]. A write puts req_wdata[7:0] on bus_wdata[7:0]. A read returns bus_rdata[7:0] in rdata[7:0] with rdata[15:8] = 0.
- R3: A byte access to an odd address runs one cycle with bus_lo_en_n = 1, bus_hi_en_n = 0 and bus_addr = addr[19:1]. A write puts req_wdata[7:0] on bus_wdata[15:8]. A read returns bus_rdata[15:8] in rdata[7:0] with rdata[15:8] = 0.
- R4: A word access to an even address runs one cycle with both enables at 0. Write data goes through unchanged. The read result equals bus_rdata.
- R5: A word access to an odd address X runs exactly two cycles.
  - The first cycle has bus_addr = X[19:1], bus_lo_en_n = 1 and bus_hi_en_n = 0, and carries data bits 7:0 on bus lane 15:8.
  - The second cycle has bus_addr = (X+1)[19:1], bus_lo_en_n = 0 and bus_hi_en_n = 1, and carries data bits 15:8 on bus lane 7:0.
- R6: The second-cycle address is taken modulo 2^20, so an odd word at 0xFFFFF uses word address 0 in its second cycle.
- R7: An odd-word read returns the first-cycle byte (from bus lane 15:8) in rdata[7:0] and the second-cycle byte (from bus lane 7:0) in rdata[15:8].
- R8: While bus_ready is low, the running cycle holds bus_cyc, bus_addr, both enables, bus_we and bus_wdata unchanged.
- R9: done is a one-cycle pulse in the clock cycle after the final cycle's ready is sampled. rdata is valid while done is high.
- R10: busy is high from the cycle after a request is accepted through the done cycle. A req_valid that arrives while busy is ignored.
- R11: bus_we is high during every cycle of a write access and low during every cycle of a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished pulse |
| rdata | output | 16 | Assembled read result |
| bus_cyc | output | 1 | External cycle active |
| bus_addr | output | 19 | Word address shared by both banks |
| bus_lo_en_n | output | 1 | Low-bank enable, active low |
| bus_hi_en_n | output | 1 | High-bank enable, active low |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both banks |
| bus_ready | input | 1 | Ends the current external cycle |

## Verification
The bench aims at the odd-word split:
- A sequencer that reversed the lane order, or reused the first word address, would corrupt memory at the wrong bank location.
- A sequencer that swapped the result bytes would fail the reassembly check.

An odd word at 0xFFFFF checks the address wrap. A design that carried into a 21st bit, or saturated, would write its high byte somewhere other than address 0. A byte read follow-up catches this. Garbage on the unselected lane catches a design that reads the wrong half or leaks into the upper result byte. Long ready stalls, with stray requests injected meanwhile, expose a design that advances early, restarts mid-access, or pulses done more than once.

// File: rtl/bls_pkg.sv
package bls_pkg;

  // Sequencer phases of one access.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FIN    = 2'd3
  } seq_state_e;

  // Bit 0 enables the low (even) bank, bit 1 the high (odd) bank.
  typedef enum logic [1:0] {
    LN_NONE = 2'b00,
    LN_LO   = 2'b01,
    LN_HI   = 2'b10,
    LN_BOTH = 2'b11
  } lane_e;

endpackage

// File: rtl/bls_seq_fsm.sv
module bls_seq_fsm
  import bls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic split,
  input  logic bus_ready,
  output logic accept,
  output logic cyc,
  output logic second,
  output logic beat_done,
  output logic done,
  output logic busy
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_FIRST;
      ST_FIRST:  if (bus_ready) st_d = split ? ST_SECOND : ST_FIN;
      ST_SECOND: if (bus_ready) st_d = ST_FIN;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign cyc       = (st_q == ST_FIRST) || (st_q == ST_SECOND);
  assign second    = (st_q == ST_SECOND);
  assign beat_done = cyc && bus_ready;
  assign done      = (st_q == ST_FIN);
  assign busy      = (st_q != ST_IDLE);

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy stays high until the done cycle
  a_r10_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R8: a stalled cycle keeps its phase
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cyc && !bus_ready |=> cyc && (second == $past(second)));

  // R5: a second cycle occurs only for a split access
  a_r5_second_needs_split: assert property (@(posedge clk) disable iff (!rst_n)
    second |-> split);

endmodule

// File: rtl/bls_lane_map.sv
module bls_lane_map
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic                word_q,
  input  logic                second,
  input  logic [2*LANE_W-1:0] wdata_q,
  output logic [ADDR_W-2:0]   waddr,
  output lane_e               lanes,
  output logic [2*LANE_W-1:0] lane_wdata
);

  localparam int WA_W = ADDR_W - 1;

  logic              odd;
  logic [LANE_W-1:0] beat_byte;

  assign odd = addr_q[0];

  // The second cycle of a split word addresses X+1; with X odd that is
  // the next word, wrapping naturally within WA_W bits.
  assign waddr = addr_q[ADDR_W-1:1] + {{(WA_W-1){1'b0}}, second};

  always_comb begin
    if (!word_q)      lanes = odd ? LN_HI : LN_LO;
    else if (!odd)    lanes = LN_BOTH;
    else              lanes = second ? LN_LO : LN_HI;
  end

  assign beat_byte = second ? wdata_q[2*LANE_W-1:LANE_W] : wdata_q[LANE_W-1:0];

  always_comb begin
    unique case (lanes)
      LN_BOTH: lane_wdata = wdata_q;
      LN_HI:   lane_wdata = {beat_byte, {LANE_W{1'b0}}};
      default: lane_wdata = {{LANE_W{1'b0}}, beat_byte};
    endcase
  end

endmodule

// File: rtl/bls_rd_gather.sv
module bls_rd_gather
  import bls_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  lane_e               lanes,
  input  logic                second,
  input  logic [2*LANE_W-1:0] bus_rdata,
  output logic [2*LANE_W-1:0] rdata
);

  logic [2*LANE_W-1:0] rd_q, rd_d;
  logic [LANE_W-1:0]   lo_b, hi_b;

  assign lo_b = bus_rdata[LANE_W-1:0];
  assign hi_b = bus_rdata[2*LANE_W-1:LANE_W];

  always_comb begin
    rd_d = rd_q;
    if (cap_en) begin
      unique case (lanes)
        LN_BOTH: rd_d = bus_rdata;
        LN_HI:   rd_d = {{LANE_W{1'b0}}, hi_b};
        LN_LO:   rd_d = second ? {lo_b, rd_q[LANE_W-1:0]} : {{LANE_W{1'b0}}, lo_b};
        default: rd_d = rd_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

  // R7: the second cycle of a split read keeps the first-cycle byte
  a_r7_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && second |=> rdata[LANE_W-1:0] == $past(rdata[LANE_W-1:0]));

endmodule

// File: rtl/bank_lane_seq.sv
module bank_lane_seq
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_word,
  input  logic                req_write,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*LANE_W-1:0] rdata,
  output logic                bus_cyc,
  output logic [ADDR_W-2:0]   bus_addr,
  output logic                bus_lo_en_n,
  output logic                bus_hi_en_n,
  output logic                bus_we,
  output logic [2*LANE_W-1:0] bus_wdata,
  input  logic [2*LANE_W-1:0] bus_rdata,
  input  logic                bus_ready
);

  localparam int DATA_W = 2 * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic              word_q, write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, cyc, second, beat_done, split;
  lane_e             lanes;
  logic [DATA_W-1:0] lane_wdata;
  logic [ADDR_W-2:0] waddr;

  // Request capture, enabled only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  assign split = word_q & addr_q[0];

  bls_seq_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .split     (split),
    .bus_ready (bus_ready),
    .accept    (accept),
    .cyc       (cyc),
    .second    (second),
    .beat_done (beat_done),
    .done      (done),
    .busy      (busy)
  );

  bls_lane_map #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_map (
    .addr_q     (addr_q),
    .word_q     (word_q),
    .second     (second),
    .wdata_q    (wdata_q),
    .waddr      (waddr),
    .lanes      (lanes),
    .lane_wdata (lane_wdata)
  );

  bls_rd_gather #(.LANE_W(LANE_W)) i_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (beat_done && !write_q),
    .lanes     (lanes),
    .second    (second),
    .bus_rdata (bus_rdata),
    .rdata     (rdata)
  );

  assign bus_cyc     = cyc;
  assign bus_addr    = waddr;
  assign bus_lo_en_n = ~(cyc & lanes[0]);
  assign bus_hi_en_n = ~(cyc & lanes[1]);
  assign bus_we      = cyc & write_q;
  assign bus_wdata   = (cyc & write_q) ? lane_wdata : '0;

  // R1: outside a cycle both banks and the strobe are quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> bus_lo_en_n && bus_hi_en_n && !bus_we);

  // R8: a stalled cycle holds every bus output
  a_r8_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ready |=> bus_cyc && $stable(bus_addr) && $stable(bus_lo_en_n)
      && $stable(bus_hi_en_n) && $stable(bus_we) && $stable(bus_wdata));

  // R4: every running cycle enables at least one bank
  a_r4_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !(bus_lo_en_n && bus_hi_en_n));

  // R9: done follows a completed bus cycle
  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_cyc && bus_ready));

  // R11: strobe never outside a cycle
  a_r11_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_cyc);

endmodule

// File: tb/test_bank_lane_seq.sv
module test_bank_lane_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [19:0] req_addr;
  logic        req_word, req_write;
  logic [15:0] req_wdata;
  logic        busy, done;
  logic [15:0] rdata;
  logic        bus_cyc;
  logic [18:0] bus_addr;
  logic        bus_lo_en_n, bus_hi_en_n, bus_we;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] mem [int unsigned];

  always #10 clk = ~clk;

  bank_lane_seq i_bank_lane_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .bus_lo_en_n(bus_lo_en_n), .bus_hi_en_n(bus_hi_en_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  function automatic logic [7:0] mem_rd(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " lo_en_n idle"}, 32'(bus_lo_en_n), 32'd1);
    chk({tag, " hi_en_n idle"}, 32'(bus_hi_en_n), 32'd1);
    chk({tag, " we idle"}, 32'(bus_we), 32'd0);
    chk({tag, " cyc idle"}, 32'(bus_cyc), 32'd0);
  endtask

  task automatic run_access(input logic [19:0] a, input bit w, input bit wr,
                            input logic [15:0] d, input int stall_pct);
    logic [19:0] na;
    int          n, k, guard;
    string       kt;
    logic [15:0] exp_rd;
    na = a + 20'd1;
    n  = (w && a[0]) ? 2 : 1;
    if (!w) kt = a[0] ? "R3" : "R2";
    else if (!a[0]) kt = "R4";
    else kt = (a == 20'hFFFFF) ? "R6" : "R5";
    exp_rd = w ? {mem_rd(na), mem_rd(a)} : {8'h00, mem_rd(a)};

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; guard = 0;
    while (!done && guard < 2000) begin
      logic [18:0] ea;
      logic        ea0, ebh, rdy;
      logic [7:0]  elo, ehi;
      guard++;
      rdy = 1'b0;
      if (bus_cyc) begin
        if (!w)        begin ea = a[19:1]; ea0 = a[0];  ebh = !a[0]; elo = d[7:0];  ehi = d[7:0];  end
        else if (!a[0]) begin ea = a[19:1]; ea0 = 1'b0; ebh = 1'b0;  elo = d[7:0];  ehi = d[15:8]; end
        else if (k == 0) begin ea = a[19:1]; ea0 = 1'b1; ebh = 1'b0; elo = 8'h00;   ehi = d[7:0];  end
        else            begin ea = na[19:1]; ea0 = 1'b0; ebh = 1'b1; elo = d[15:8]; ehi = 8'h00;   end
        chk({kt, " addr"}, 32'(bus_addr), 32'(ea));
        chk({kt, " lo_en_n"}, 32'(bus_lo_en_n), 32'(ea0));
        chk({kt, " hi_en_n"}, 32'(bus_hi_en_n), 32'(ebh));
        chk("R11 we", 32'(bus_we), 32'(wr));
        chk("R10 busy in cycle", 32'(busy), 32'd1);
        if (wr && !ea0) chk({kt, " wlo"}, 32'(bus_wdata[7:0]), 32'(elo));
        if (wr && !ebh) chk({kt, " whi"}, 32'(bus_wdata[15:8]), 32'(ehi));
        bus_rdata[7:0]  = !bus_lo_en_n ? mem_rd({bus_addr, 1'b0}) : 8'($urandom);
        bus_rdata[15:8] = !bus_hi_en_n ? mem_rd({bus_addr, 1'b1}) : 8'($urandom);
        rdy = (($urandom % 100) >= stall_pct);
        bus_ready = rdy;
        if (rdy && bus_we) begin
          if (!bus_lo_en_n) mem[int'({bus_addr, 1'b0})] = bus_wdata[7:0];
          if (!bus_hi_en_n) mem[int'({bus_addr, 1'b1})] = bus_wdata[15:8];
        end
        if (!rdy && ($urandom % 3 == 0)) begin
          req_valid = 1'b1; req_addr = 20'($urandom); req_word = 1'($urandom);
          req_write = 1'($urandom); req_wdata = 16'($urandom);
        end
      end else begin
        bus_ready = 1'b0;
      end
      @(posedge clk);
      if (rdy) k++;
      @(negedge clk);
      req_valid = 1'b0;
      bus_ready = 1'b0;
    end
    chk("R9 done seen", 32'(done), 32'd1);
    chk({kt, " R9 beat count"}, 32'(k), 32'(n));
    chk("R10 busy at done", 32'(busy), 32'd1);
    if (!wr) chk((w && a[0]) ? "R7 rdata" : {kt, " rdata"}, 32'(rdata), 32'(exp_rd));
    @(posedge clk);
    @(negedge clk);
    chk("R9 done single", 32'(done), 32'd0);
    chk("R10 busy cleared", 32'(busy), 32'd0);
    chk_idle("R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0; bus_rdata = '0; bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset");
    chk("R10 busy reset", 32'(busy), 32'd0);
    chk("R9 done reset", 32'(done), 32'd0);

    // Directed corner cases.
    run_access(20'h00100, 1'b0, 1'b1, 16'hAA11, 20);  // R2 byte even write
    run_access(20'h00100, 1'b0, 1'b0, 16'h0000, 20);
    run_access(20'h00101, 1'b0, 1'b1, 16'hBB22, 20);  // R3 byte odd write
    run_access(20'h00101, 1'b0, 1'b0, 16'h0000, 20);
    run_access(20'h00100, 1'b1, 1'b0, 16'h0000, 0);   // R4 word even read
    run_access(20'h00200, 1'b1, 1'b1, 16'hC3D4, 0);   // R4 word even write
    run_access(20'h00200, 1'b1, 1'b0, 16'h0000, 0);
    run_access(20'h12345, 1'b1, 1'b1, 16'h5A69, 50);  // R5 odd word write
    run_access(20'h12345, 1'b1, 1'b0, 16'h0000, 50);  // R7 odd word read
    run_access(20'h12346, 1'b0, 1'b0, 16'h0000, 0);   // R5 high byte at X+1
    run_access(20'hFFFFF, 1'b1, 1'b1, 16'h7E81, 0);   // R6 wrap write
    run_access(20'h00000, 1'b0, 1'b0, 16'h0000, 0);   // R6 high byte at 0
    run_access(20'hFFFFF, 1'b1, 1'b0, 16'h0000, 0);   // R6 wrap read
    run_access(20'h0ABC1, 1'b1, 1'b0, 16'h0000, 90);  // R8 long stalls

    // Constrained random traffic in a small window plus the top edge.
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      a = ($urandom % 5 == 0) ? (20'hFFFF0 | 20'($urandom % 16)) : 20'($urandom % 64);
      run_access(a, 1'($urandom), 1'($urandom), 16'($urandom), int'($urandom % 70));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule